// File: doc/BRIEF.md
# Synchronous DRAM Read Latency Output Pipeline

This block is the device-side output stage of a synchronous DRAM model. A command decoder outside the block reports each read column command, each continuing burst beat, each burst-ending command (precharge or burst stop) and each write beat as single-cycle strobes. The memory array returns one data word for each live read beat in the cycle after that beat's strobe edge. The block delays these words by the programmed read latency of two or three clocks and presents them on an 8-bit data bus together with an output-enable.

Every word in the pipeline travels with a valid bit. The output-enable is the valid bit at the selected output stage, gated by the data mask after a fixed two-clock delay. On the write side the block samples the bus and the mask on the same edge. The array then receives a registered write strobe and word, and a masked beat produces no strobe. The data bus is shared for input and output: `dqOut` and `dqOe` drive the pad and `dqIn` reads it back.

All inputs are sampled on the rising clock edge, and all outputs change only on that edge.

Top module: `sdrReadPipe`

## Requirements
- R1: With `casLat3`=0, a live read beat strobed at edge n puts its word on `dqOut` with `dqOe`=1 for sampling at edge n+2. The word is the one `arrData` carried at edge n+1.
- R2: With `casLat3`=1, the same word is sampled at edge n+3, and `dqOe`=1 at that edge.
- R3: `rdCmd` may be asserted on every cycle. Each one is a live beat, its word follows the previous word with no idle cycle, and it reopens the burst even when a burst is already running.
- R4: `dqm`=1 at edge n forces `dqOe`=0 at edge n+2, whatever the valid bit at the output stage holds.
- R5: `stopCmd`=1 at edge n closes the open burst. Beats strobed before edge n still reach the bus. From edge n+L onward (L = 2 or 3), nothing from that burst is driven.
- R6: A write beat (`wrBeat`=1) at edge n with `dqm`=0 gives `wrStb`=1 and `wrData` equal to `dqIn` of edge n, both visible after edge n. With `dqm`=1 at edge n, `wrStb` stays 0.
- R7: While `rst_n`=0 and in the cycle after reset is released, `dqOe`=0 and `wrStb`=0. Reset clears every valid bit and the mask delay.
- R8: `rdBeat` is a live beat only when a burst is open, that is after `rdCmd` and before `stopCmd`. At any other time it has no effect on `dqOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples and updates everything |
| rst_n | input | 1 | Active-low synchronous reset |
| casLat3 | input | 1 | Read latency select: 0 = two clocks, 1 = three clocks |
| rdCmd | input | 1 | Read column command strobe; opens a burst and is a live beat |
| rdBeat | input | 1 | Continuing burst beat strobe |
| stopCmd | input | 1 | Precharge or burst stop strobe; closes the burst |
| arrData | input | 8 | Array word for the beat strobed one edge earlier |
| dqm | input | 1 | Data mask |
| wrBeat | input | 1 | Write beat strobe |
| dqIn | input | 8 | Data bus as seen at the pad |
| dqOut | output | 8 | Data bus drive value |
| dqOe | output | 1 | Data bus output-enable (0 = high impedance) |
| wrData | output | 8 | Registered write word to the array |
| wrStb | output | 1 | Registered, unmasked write strobe to the array |

## Verification
A lost or duplicated valid bit in the latency chain makes `dqOe` wrong at exactly edge n+L, and a stage-select error moves the word one cycle early or late. Both show up within three clocks of the beat. If the mask delay is one stage too short or too long, the enable drops a cycle early or late relative to `dqm`. A burst flag that does not close leaves `dqOe` high at edge n+L after a stop, and one that opens when it should not drives the bus for orphan beats. For these reasons every read-side cycle is compared against a model of beats, stops and mask history for both latency settings.

// File: rtl/sdrReadPipePkg.sv
package sdrReadPipePkg;
  // Strobes from the control half to the datapath half, one cycle's worth.
  typedef struct packed {
    logic beatLive;  // read beat accepted at this edge
    logic wrLive;    // unmasked write beat at this edge
    logic lat3;      // long latency selected
    logic maskLate;  // read mask, delayed to line up with the output stage
  } pipeCtrlT;
endpackage

// File: rtl/sdrReadCtrl.sv
module sdrReadCtrl
  import sdrReadPipePkg::*;
#(
  parameter int DQM_RD_DELAY = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     casLat3,
  input  logic     rdCmd,
  input  logic     rdBeat,
  input  logic     stopCmd,
  input  logic     dqm,
  input  logic     wrBeat,
  output pipeCtrlT ctrl
);
  logic burstOn;
  logic [DQM_RD_DELAY-1:0] dqmSh;

  // A read command always starts a burst; a stop ends it on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)        burstOn <= 1'b0;
    else if (rdCmd)    burstOn <= 1'b1;
    else if (stopCmd)  burstOn <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dqmSh <= '0;
    else        dqmSh <= {dqmSh[DQM_RD_DELAY-2:0], dqm};
  end

  always_comb begin
    ctrl.beatLive = rdCmd | (rdBeat & burstOn & ~stopCmd);
    ctrl.wrLive   = wrBeat & ~dqm;
    ctrl.lat3     = casLat3;
    ctrl.maskLate = dqmSh[DQM_RD_DELAY-1];
  end
endmodule

// File: rtl/sdrReadData.sv
module sdrReadData
  import sdrReadPipePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LAT_LO = 2,
  parameter int LAT_HI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pipeCtrlT          ctrl,
  input  logic [DATA_W-1:0] arrData,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStb
);
  localparam int STAGES = LAT_HI - 1;

  logic              beatQ;
  logic [STAGES:1]   stVld;
  logic [DATA_W-1:0] stDat [STAGES:1];

  // Valid for the beat whose array word arrives during the next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) beatQ <= 1'b0;
    else        beatQ <= ctrl.beatLive;
  end

  // Stage k is loaded at edge n+k for a beat strobed at edge n.
  for (genvar k = 1; k <= STAGES; k++) begin : gStage
    if (k == 1) begin : gHead
      always_ff @(posedge clk) begin
        if (!rst_n) stVld[1] <= 1'b0;
        else        stVld[1] <= beatQ;
      end
      always_ff @(posedge clk) stDat[1] <= arrData;
    end else begin : gTail
      always_ff @(posedge clk) begin
        if (!rst_n) stVld[k] <= 1'b0;
        else        stVld[k] <= stVld[k-1];
      end
      always_ff @(posedge clk) stDat[k] <= stDat[k-1];
    end
  end

  always_comb begin
    if (ctrl.lat3) begin
      dqOut = stDat[LAT_HI-1];
      dqOe  = stVld[LAT_HI-1] & ~ctrl.maskLate;
    end else begin
      dqOut = stDat[LAT_LO-1];
      dqOe  = stVld[LAT_LO-1] & ~ctrl.maskLate;
    end
  end

  // Write side: mask applies on the very edge the data is taken.
  always_ff @(posedge clk) begin
    if (!rst_n) wrStb <= 1'b0;
    else        wrStb <= ctrl.wrLive;
  end
  always_ff @(posedge clk) wrData <= dqIn;
endmodule

// File: rtl/sdrReadPipe.sv
module sdrReadPipe
  import sdrReadPipePkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int LAT_LO       = 2,
  parameter int LAT_HI       = 3,
  parameter int DQM_RD_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              casLat3,
  input  logic              rdCmd,
  input  logic              rdBeat,
  input  logic              stopCmd,
  input  logic [DATA_W-1:0] arrData,
  input  logic              dqm,
  input  logic              wrBeat,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStb
);
  pipeCtrlT ctrl;

  sdrReadCtrl #(.DQM_RD_DELAY(DQM_RD_DELAY)) uCtrl (
    .clk(clk), .rst_n(rst_n), .casLat3(casLat3), .rdCmd(rdCmd),
    .rdBeat(rdBeat), .stopCmd(stopCmd), .dqm(dqm), .wrBeat(wrBeat),
    .ctrl(ctrl)
  );

  sdrReadData #(.DATA_W(DATA_W), .LAT_LO(LAT_LO), .LAT_HI(LAT_HI)) uData (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .arrData(arrData), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .wrData(wrData), .wrStb(wrStb)
  );
endmodule

// File: rtl/sdrReadPipeChk.sv
module sdrReadPipeChk (
  input logic clk,
  input logic rst_n,
  input logic casLat3,
  input logic rdCmd,
  input logic stopCmd,
  input logic dqm,
  input logic wrBeat,
  input logic dqOe,
  input logic wrStb
);
  assert_lat2_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!casLat3 && !$past(casLat3) && $past(rdCmd, 2) && !$past(dqm, 2)) |-> dqOe);

  assert_lat3_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (casLat3 && $past(casLat3) && $past(casLat3, 2) && $past(rdCmd, 3) && !$past(dqm, 2)) |-> dqOe);

  assert_mask_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dqOe |-> !$past(dqm, 2));

  assert_stop_lat2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!casLat3 && !$past(casLat3, 2) && $past(stopCmd, 2) && !$past(rdCmd, 2)) |-> !dqOe);

  assert_stop_lat3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (casLat3 && $past(casLat3, 3) && $past(stopCmd, 3) && !$past(rdCmd, 3)) |-> !dqOe);

  assert_write_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrStb |-> ($past(wrBeat) && !$past(dqm)));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    $past(!rst_n) |-> (!dqOe && !wrStb));
endmodule

bind sdrReadPipe sdrReadPipeChk chk (
  .clk(clk), .rst_n(rst_n), .casLat3(casLat3), .rdCmd(rdCmd),
  .stopCmd(stopCmd), .dqm(dqm), .wrBeat(wrBeat), .dqOe(dqOe), .wrStb(wrStb)
);

// File: tb/sdrReadPipe_test.sv
`timescale 1ns/1ps
module sdrReadPipe_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic casLat3 = 1'b0, rdCmd = 1'b0, rdBeat = 1'b0, stopCmd = 1'b0;
  logic dqm = 1'b0, wrBeat = 1'b0;
  logic [7:0] arrData = '0, dqIn = '0;
  logic [7:0] dqOut, wrData;
  logic dqOe, wrStb;

  always #2 clk = ~clk;

  sdrReadPipe uut (
    .clk(clk), .rst_n(rst_n), .casLat3(casLat3), .rdCmd(rdCmd),
    .rdBeat(rdBeat), .stopCmd(stopCmd), .arrData(arrData), .dqm(dqm),
    .wrBeat(wrBeat), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .wrData(wrData), .wrStb(wrStb)
  );

  int errs = 0, checks = 0, cyc = 0;
  bit mOn = 0;
  string curTag = "";
  bit hLive [0:2047];
  bit hDqm  [0:2047];
  bit hWr   [0:2047];
  logic [7:0] hDin [0:2047];

  function automatic logic [7:0] dataFor(int j);
    return 8'((j * 37 + 5) & 255);
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s at step %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  // One clock: check what the requirements predict for the coming edge, then drive it.
  task automatic step(bit rd, bit beat, bit stop, bit dm, bit wr, logic [7:0] din);
    int L;
    bit eLive, eDm, eOe;
    string t;
    @(negedge clk);
    L = casLat3 ? 3 : 2;
    eLive = (cyc - L >= 0) ? hLive[cyc - L] : 1'b0;
    eDm   = (cyc >= 2) ? hDqm[cyc - 2] : 1'b0;
    eOe   = eLive & !eDm;
    if (eLive && eDm) t = "R4";
    else if (eOe) t = (L == 3) ? "R2" : "R1";
    else t = "R5/R8";
    t = {t, "/", curTag};
    check(t, "dqOe", {7'd0, dqOe}, {7'd0, eOe});
    if (eOe) check(t, "dqOut", dqOut, dataFor(cyc - L));
    if (cyc >= 1) begin
      check("R6", "wrStb", {7'd0, wrStb}, {7'd0, hWr[cyc - 1]});
      if (hWr[cyc - 1]) check("R6", "wrData", wrData, hDin[cyc - 1]);
    end
    rdCmd = rd; rdBeat = beat; stopCmd = stop; dqm = dm; wrBeat = wr; dqIn = din;
    arrData = dataFor(cyc - 1);
    hLive[cyc] = rd | (beat & mOn & !stop);
    mOn = rd ? 1'b1 : (stop ? 1'b0 : mOn);
    hDqm[cyc] = dm;
    hWr[cyc]  = wr & !dm;
    hDin[cyc] = din;
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    check("R7", "dqOe in reset", {7'd0, dqOe}, 8'd0);
    check("R7", "wrStb in reset", {7'd0, wrStb}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "dqOe after release", {7'd0, dqOe}, 8'd0);
    check("R7", "wrStb after release", {7'd0, wrStb}, 8'd0);
  endtask

  task automatic tBurst(bit lat3);
    casLat3 = lat3;
    curTag = lat3 ? "R2" : "R1";
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    idle(5);
  endtask

  task automatic tSeamless(bit lat3);
    casLat3 = lat3;
    curTag = "R3";
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    idle(5);
  endtask

  task automatic tMaskRead(bit lat3);
    casLat3 = lat3;
    curTag = "R4";
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0);
    step(0, 1, 0, 1, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    idle(5);
  endtask

  task automatic tStop(bit lat3);
    casLat3 = lat3;
    curTag = "R5";
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0);
    idle(5);
  endtask

  task automatic tOrphan;
    casLat3 = 1'b0;
    curTag = "R8";
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    idle(5);
  endtask

  task automatic tWrite;
    curTag = "R6";
    step(0, 0, 0, 0, 1, 8'hA5);
    step(0, 0, 0, 1, 1, 8'h3C);
    step(0, 0, 0, 0, 1, 8'h7E);
    step(0, 0, 0, 0, 0, 8'hFF);
    step(0, 0, 0, 1, 1, 8'h11);
    step(0, 0, 0, 0, 1, 8'h00);
    idle(3);
  endtask

  initial begin
    #(4 * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tReset();
    tBurst(0);
    tBurst(1);
    tSeamless(1);
    tSeamless(0);
    tMaskRead(0);
    tMaskRead(1);
    tStop(0);
    tStop(1);
    tOrphan();
    tWrite();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule